// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one read or write command into the stream of column addresses that a synchronous DRAM burst touches. A 12-bit mode word, written through a small load port, selects how many beats a burst has (1, 2, 4, 8 or a whole 256-column row), whether the beats inside an aligned block follow a wrapping count or an XOR pattern, and whether writes are cut down to a single beat. The CAS latency field of the mode word is decoded and driven out for the rest of the controller; it does not delay anything here.

When a command is accepted, the first column appears on the next clock and one further column follows on each clock after that, flagged by a valid bit and, for fixed-length bursts, a last-beat bit. A whole-row burst keeps stepping (wrapping from 255 to 0) until the terminate input stops it. A new command during a burst abandons the old one. Mode words with a reserved length code, or a whole-row length paired with the XOR order, are refused and raise an error flag; words whose top bit is set address another register and are ignored.

Top module: `burst_col_seq`

## Requirements
- R1: After reset the mode is 1 beat, wrapping order, writes bursting, CAS field 3'b010: cas_lat reads 2, mode_error is 0, busy is 0, and a read gives one beat with beat_last high.
- R2: Length code mode_wdata[2:0] = 3'b001, 3'b010, 3'b011 gives 2, 4, 8 beats; beat_last is high on the final beat only, and the cycle after it beat_valid and busy are low.
- R3: With mode_wdata[3] = 0, beat i of a burst of length L addresses column (start with its low log2(L) bits replaced by (start + i) mod L); bits above the block stay fixed (e.g. length 4, start 0x81 gives 0x81, 0x82, 0x83, 0x80).
- R4: With mode_wdata[3] = 1, beat i addresses start XOR i (e.g. length 8, start 5 gives 5,4,7,6,1,0,3,2).
- R5: With length code 3'b000 the type bit mode_wdata[3] is ignored: one beat at the start column, and the word is accepted without error.
- R6: Length code 3'b111 gives a whole-row burst: column start + i modulo 256, beat_last never high, running until terminated.
- R7: term high at a clock edge while busy (and no command) ends the burst; from the next cycle beat_valid and busy are low.
- R8: With mode_wdata[9] = 1, a write command (cmd_is_write = 1) gives a single beat while a read gives the full programmed length.
- R9: A word with mode_wdata[11] = 0 and a length code of 3'b100, 3'b101, 3'b110, or code 3'b111 with mode_wdata[3] = 1, sets mode_error and leaves the mode unchanged; the next accepted word clears mode_error.
- R10: A word with mode_wdata[11] = 1 changes nothing: mode, cas_lat and mode_error keep their values.
- R11: A command accepted during a burst abandons it; the next cycle shows beat 0 of the new burst.
- R12: cas_lat equals bits [6:4] of the last accepted mode word.
- R13: busy is high on every cycle that a beat is presented and low when none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Load strobe for the mode word |
| mode_wdata | input | 12 | Mode word |
| cmd_valid | input | 1 | Command accepted this edge |
| cmd_is_write | input | 1 | 1 for a write command, 0 for a read |
| cmd_col | input | 8 | Starting column of the command |
| term | input | 1 | Ends the running burst |
| col_out | output | 8 | Column of the current beat |
| beat_valid | output | 1 | col_out holds a beat |
| beat_last | output | 1 | Final beat of a fixed-length burst |
| busy | output | 1 | A burst is in progress |
| cas_lat | output | 3 | Decoded CAS latency field |
| mode_error | output | 1 | Last non-extended mode word was refused |

## Verification
A command or mode word sampled at one rising edge shows its effect right after that edge: beat 0, cas_lat and mode_error are all due one cycle after the stimulus, and each further beat one cycle after the one before. A terminate or the last beat takes effect at the following edge, so idle is due one cycle later. The bench drives inputs on falling edges and reads outputs on the falling edge after the edge that should have changed them, walking through a burst one falling edge per beat and comparing against its own block-base-plus-offset formula.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int COL_W  = 8;
  localparam int MODE_W = 12;

  localparam logic [2:0] BL_1    = 3'b000;
  localparam logic [2:0] BL_2    = 3'b001;
  localparam logic [2:0] BL_4    = 3'b010;
  localparam logic [2:0] BL_8    = 3'b011;
  localparam logic [2:0] BL_FULL = 3'b111;

  typedef struct packed {
    logic [2:0] len_code;
    logic       xor_order;
    logic [2:0] cas;
    logic       write_single;
  } mode_fields_t;

  // A length code that is reserved, or a whole row with XOR order.
  function automatic logic mode_refused(input logic [2:0] code, input logic xor_order);
    case (code)
      BL_1, BL_2, BL_4, BL_8: mode_refused = 1'b0;
      BL_FULL:                mode_refused = xor_order;
      default:                mode_refused = 1'b1;
    endcase
  endfunction

  // Offset mask of the aligned block for a length code.
  function automatic logic [COL_W-1:0] block_mask(input logic [2:0] code);
    case (code)
      BL_2:    block_mask = COL_W'(1);
      BL_4:    block_mask = COL_W'(3);
      BL_8:    block_mask = COL_W'(7);
      BL_FULL: block_mask = {COL_W{1'b1}};
      default: block_mask = '0;
    endcase
  endfunction

  // Column of beat idx inside a burst.
  function automatic logic [COL_W-1:0] beat_column(input logic [COL_W-1:0] start,
                                                   input logic [COL_W-1:0] idx,
                                                   input logic [COL_W-1:0] mask,
                                                   input logic             xor_order);
    logic [COL_W-1:0] sum;
    sum = start + idx;
    if (xor_order) beat_column = start ^ (idx & mask);
    else           beat_column = (start & ~mask) | (sum & mask);
  endfunction
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
  import bcs_pkg::*;
#(
  parameter logic [MODE_W-1:0] RESET_WORD = 12'h020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [MODE_W-1:0] wdata,
  output mode_fields_t      fields,
  output logic              refused
);
  logic [MODE_W-1:0] word_q;
  logic              refused_q;
  logic              base_sel;
  logic              bad_word;

  assign base_sel = we && !wdata[MODE_W-1];
  assign bad_word = mode_refused(wdata[2:0], wdata[3]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q    <= RESET_WORD;
      refused_q <= 1'b0;
    end else if (base_sel) begin
      refused_q <= bad_word;
      if (!bad_word) word_q <= wdata;
    end
  end

  always_comb begin
    fields.len_code     = word_q[2:0];
    fields.xor_order    = word_q[3];
    fields.cas          = word_q[6:4];
    fields.write_single = word_q[9];
  end

  assign refused = refused_q;
endmodule

// File: rtl/bcs_beat_gen.sv
module bcs_beat_gen
  import bcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_cmd,
  input  logic             is_write,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop_req,
  input  mode_fields_t     fields,
  output logic [COL_W-1:0] col,
  output logic             valid,
  output logic             last,
  output logic             whole_row
);
  logic             active_q;
  logic             xor_q;
  logic             full_q;
  logic [COL_W-1:0] mask_q;
  logic [COL_W-1:0] start_q;
  logic [COL_W-1:0] idx_q;

  logic [2:0]       eff_code;
  logic             final_beat;

  assign eff_code   = (is_write && fields.write_single) ? BL_1 : fields.len_code;
  assign final_beat = active_q && !full_q && (idx_q == mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      xor_q    <= 1'b0;
      full_q   <= 1'b0;
      mask_q   <= '0;
      start_q  <= '0;
      idx_q    <= '0;
    end else if (start_cmd) begin
      active_q <= 1'b1;
      start_q  <= start_col;
      idx_q    <= '0;
      mask_q   <= block_mask(eff_code);
      full_q   <= (eff_code == BL_FULL);
      xor_q    <= fields.xor_order && (eff_code != BL_1);
    end else if (active_q) begin
      if (stop_req || final_beat) active_q <= 1'b0;
      else                        idx_q    <= idx_q + 1'b1;
    end
  end

  assign col       = active_q ? beat_column(start_q, idx_q, mask_q, xor_q) : '0;
  assign valid     = active_q;
  assign last      = final_beat;
  assign whole_row = active_q && full_q;
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter logic [MODE_W-1:0] RESET_WORD = 12'h020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              cmd_valid,
  input  logic              cmd_is_write,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              term,
  output logic [COL_W-1:0]  col_out,
  output logic              beat_valid,
  output logic              beat_last,
  output logic              busy,
  output logic [2:0]        cas_lat,
  output logic              mode_error
);
  mode_fields_t mode_now;
  logic         burst_full;

  bcs_mode_reg #(.RESET_WORD(RESET_WORD)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (mode_we),
    .wdata   (mode_wdata),
    .fields  (mode_now),
    .refused (mode_error)
  );

  bcs_beat_gen u_beat (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_cmd (cmd_valid),
    .is_write  (cmd_is_write),
    .start_col (cmd_col),
    .stop_req  (term),
    .fields    (mode_now),
    .col       (col_out),
    .valid     (beat_valid),
    .last      (beat_last),
    .whole_row (burst_full)
  );

  assign busy    = beat_valid;
  assign cas_lat = mode_now.cas;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
  import bcs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mode_we,
  input logic [MODE_W-1:0] mode_wdata,
  input logic              cmd_valid,
  input logic [COL_W-1:0]  cmd_col,
  input logic              term,
  input logic [COL_W-1:0]  col_out,
  input logic              beat_valid,
  input logic              beat_last,
  input logic              busy,
  input logic [2:0]        cas_lat,
  input logic              mode_error,
  input logic              burst_full
);
  logic word_bad;
  assign word_bad = (mode_wdata[2:0] inside {3'b100, 3'b101, 3'b110}) ||
                    (mode_wdata[2:0] == 3'b111 && mode_wdata[3]);

  p_last_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_last && !cmd_valid) |=> !busy);

  p_block_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !burst_full && !beat_last && !cmd_valid && !term)
      |=> (col_out[COL_W-1:3] == $past(col_out[COL_W-1:3])));

  p_row_no_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_full |-> !beat_last);

  p_term_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && term && !cmd_valid) |=> !beat_valid);

  p_bad_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && !mode_wdata[MODE_W-1] && word_bad) |=> (mode_error && $stable(cas_lat)));

  p_ext_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && mode_wdata[MODE_W-1]) |=> ($stable(cas_lat) && $stable(mode_error)));

  p_cmd_starts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (beat_valid && col_out == $past(cmd_col)));

  p_cas_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && !mode_wdata[MODE_W-1] && !word_bad) |=> (cas_lat == $past(mode_wdata[6:4]) && !mode_error));
endmodule

bind burst_col_seq bcs_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_we    (mode_we),
  .mode_wdata (mode_wdata),
  .cmd_valid  (cmd_valid),
  .cmd_col    (cmd_col),
  .term       (term),
  .col_out    (col_out),
  .beat_valid (beat_valid),
  .beat_last  (beat_last),
  .busy       (busy),
  .cas_lat    (cas_lat),
  .mode_error (mode_error),
  .burst_full (burst_full)
);

// File: tb/burst_col_seq_test.sv
`timescale 1ns/1ps
module burst_col_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [11:0] mode_wdata = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_is_write = 1'b0;
  logic [7:0]  cmd_col = '0;
  logic        term = 1'b0;
  logic [7:0]  col_out;
  logic        beat_valid, beat_last, busy, mode_error;
  logic [2:0]  cas_lat;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  burst_col_seq uut (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .cmd_valid(cmd_valid), .cmd_is_write(cmd_is_write), .cmd_col(cmd_col),
    .term(term), .col_out(col_out), .beat_valid(beat_valid),
    .beat_last(beat_last), .busy(busy), .cas_lat(cas_lat), .mode_error(mode_error)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected column: block base plus offset, formed with arithmetic.
  function automatic int exp_col(input int s, input int i, input int len, input bit x);
    int base, off;
    if (len == 256) return (s + i) % 256;
    base = (s / len) * len;
    off  = s % len;
    if (x) return base + (off ^ i);
    return base + ((off + i) % len);
  endfunction

  task automatic write_mode(input logic [11:0] w);
    @(negedge clk); mode_we = 1'b1; mode_wdata = w;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic issue(input bit wr, input logic [7:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd_is_write = wr; cmd_col = c;
    @(negedge clk); cmd_valid = 1'b0; cmd_is_write = 1'b0;
  endtask

  // Walks n beats starting right after issue(); checks idle afterwards if close.
  task automatic walk(input string req, input int s, input int len, input bit x,
                      input int n, input bit close);
    for (int i = 0; i < n; i++) begin
      chk({req, " col"}, col_out, exp_col(s, i, len, x));
      chk("R13 busy", busy, 1);
      chk({req, " last"}, beat_last, (len != 256 && i == len - 1) ? 1 : 0);
      if (i != n - 1 || close) @(negedge clk);
    end
    if (close) begin
      chk({req, " idle valid"}, beat_valid, 0);
      chk("R13 idle busy", busy, 0);
    end
  endtask

  task automatic t_reset;
    chk("R1 cas", cas_lat, 2);
    chk("R1 err", mode_error, 0);
    chk("R1 busy", busy, 0);
    issue(1'b0, 8'h37);
    walk("R1", 'h37, 1, 0, 1, 1);
    issue(1'b1, 8'h12);
    walk("R1", 'h12, 1, 0, 1, 1);
  endtask

  task automatic t_lengths;
    write_mode(12'h021); issue(1'b0, 8'h45); walk("R2", 'h45, 2, 0, 2, 1);
    write_mode(12'h022); issue(1'b0, 8'h81); walk("R3", 'h81, 4, 0, 4, 1);
    write_mode(12'h023); issue(1'b0, 8'hC6); walk("R2", 'hC6, 8, 0, 8, 1);
  endtask

  task automatic t_interleave;
    write_mode(12'h02B); issue(1'b0, 8'h05); walk("R4", 'h05, 8, 1, 8, 1);
    write_mode(12'h02A); issue(1'b0, 8'h3E); walk("R4", 'h3E, 4, 1, 4, 1);
  endtask

  task automatic t_len1_type;
    write_mode(12'h028);
    chk("R5 no err", mode_error, 0);
    issue(1'b0, 8'h9B); walk("R5", 'h9B, 1, 1, 1, 1);
  endtask

  task automatic t_full_row;
    write_mode(12'h027);
    issue(1'b0, 8'hFD);
    walk("R6", 'hFD, 256, 0, 6, 0);
    term = 1'b1;
    @(negedge clk); term = 1'b0;
    chk("R7 row stopped", beat_valid, 0);
    chk("R7 row busy", busy, 0);
  endtask

  task automatic t_term_fixed;
    write_mode(12'h023);
    issue(1'b0, 8'h20);
    walk("R7", 'h20, 8, 0, 3, 0);
    term = 1'b1;
    @(negedge clk); term = 1'b0;
    chk("R7 stopped", beat_valid, 0);
  endtask

  task automatic t_write_single;
    write_mode(12'h222);
    issue(1'b1, 8'h76); walk("R8 write", 'h76, 1, 0, 1, 1);
    issue(1'b0, 8'h76); walk("R8 read", 'h76, 4, 0, 4, 1);
  endtask

  task automatic t_mode_error;
    write_mode(12'h042);
    chk("R12 cas", cas_lat, 4);
    write_mode(12'h015);
    chk("R9 err", mode_error, 1);
    chk("R9 cas kept", cas_lat, 4);
    issue(1'b0, 8'h09); walk("R9 len kept", 'h09, 4, 0, 4, 1);
    write_mode(12'h01F);
    chk("R9 row+xor err", mode_error, 1);
    chk("R9 cas kept2", cas_lat, 4);
    write_mode(12'h031);
    chk("R9 cleared", mode_error, 0);
    chk("R12 cas3", cas_lat, 3);
    issue(1'b0, 8'h09); walk("R9 new len", 'h09, 2, 0, 2, 1);
  endtask

  task automatic t_ext_word;
    write_mode(12'h006);
    chk("R9 err set", mode_error, 1);
    write_mode(12'h872);
    chk("R10 err kept", mode_error, 1);
    chk("R10 cas kept", cas_lat, 3);
    issue(1'b0, 8'h55); walk("R10 len kept", 'h55, 2, 0, 2, 1);
  endtask

  task automatic t_abort;
    write_mode(12'h023);
    issue(1'b0, 8'h10);
    walk("R11 old", 'h10, 8, 0, 3, 0);
    cmd_valid = 1'b1; cmd_col = 8'hA3;
    @(negedge clk); cmd_valid = 1'b0;
    walk("R11 new", 'hA3, 8, 0, 8, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lengths();
    t_interleave();
    t_len1_type();
    t_full_row();
    t_term_fixed();
    t_write_single();
    t_mode_error();
    t_ext_word();
    t_abort();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end
endmodule